// File: doc/BRIEF.md
# USB Device Interrupt Flag Register

This block holds the interrupt flags of a USB device function controller. The packet engine raises single-cycle pulses when it sees a bus reset, an IN token for endpoint 2 with no transmit data ready, a completed setup command, or endpoint-0 transfer events. Each pulse latches a flag. Two further bits are not latched. They are sampled status levels: endpoint 1 holds received data, and endpoint 2 has a free transmit buffer.

Software reads the flags through a small register port. It clears a latched flag by writing 0 to that bit position and writing 1 to every bit it wants to keep. A second register enables individual flags. The registered interrupt request rises when any flag meets its enable bit.

Top module: `usb_irq_flags`

## Requirements
- R1: While `rst` is high at a clock edge, the flag register becomes 0x10, the enable register becomes 0x00 and `irq` becomes 0.
- R2: An event pulse sets its flag at the next edge. The bit positions are: bit 7 bus reset, bit 5 endpoint-2 transfer request, bit 3 setup received, bit 2 endpoint-0 OUT done, bit 1 endpoint-0 IN request and bit 0 endpoint-0 IN done. The flag then stays 1 until software clears it.
- R3: A write with `reg_sel`=0 clears each latched flag whose data bit is 0. A data bit of 1 leaves its flag unchanged, so writing 0xFF changes nothing.
- R4: Bit 6 follows `st_ep1_full` and bit 4 follows `st_ep2_room`, each one edge later. Writes to the flag register never change these two bits.
- R5: If an event pulse and a clearing write reach the same flag in one cycle, the flag ends up 1.
- R6: A write with `reg_sel`=1 loads the enable register. `reg_rdata` returns the flag register when `reg_sel`=0 and the enable register when `reg_sel`=1. The read path has no delay.
- R7: `irq` is 1 in the cycle after a clock edge exactly when, before that edge, some bit was 1 in both the flag register and the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the flag register, 1 selects the enable register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| ev_bus_reset | input | 1 | Pulse: bus reset detected |
| ev_ep2_in_nodata | input | 1 | Pulse: IN token on endpoint 2 with no data ready |
| ev_setup_done | input | 1 | Pulse: setup command received and acknowledged |
| ev_ep0_out_done | input | 1 | Pulse: endpoint-0 OUT transfer complete |
| ev_ep0_in_req | input | 1 | Pulse: endpoint-0 IN transfer request |
| ev_ep0_in_done | input | 1 | Pulse: endpoint-0 IN transfer complete |
| st_ep1_full | input | 1 | Level: endpoint-1 FIFO holds valid data |
| st_ep2_room | input | 1 | Level: an endpoint-2 transmit buffer can accept data |
| irq | output | 1 | Interrupt request |

## Verification
A flag cell holding a wrong value shows on `reg_rdata` in the first cycle after the faulty edge, because the read path has no delay. If its enable bit is set, the fault also shows on `irq` one edge later. A lost event, a write that clears the wrong bit, or a status bit disturbed by a write therefore shows within one or two cycles. The bench compares both outputs against a reference model after every edge. It mixes random pulses, levels and writes with directed cases: a same-cycle set and clear, a write of all ones, and a single-bit clear.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int FLAG_W = 8;

    // Bit positions; software decodes these, so they are fixed.
    localparam int B_BUS_RST     = 7;
    localparam int B_EP1_FULL    = 6;
    localparam int B_EP2_REQ     = 5;
    localparam int B_EP2_ROOM    = 4;
    localparam int B_SETUP       = 3;
    localparam int B_EP0_OUT     = 2;
    localparam int B_EP0_IN_REQ  = 1;
    localparam int B_EP0_IN_DONE = 0;

    localparam logic [FLAG_W-1:0] STATUS_MASK = FLAG_W'((1 << B_EP1_FULL) | (1 << B_EP2_ROOM));
    localparam logic [FLAG_W-1:0] LATCH_MASK  = ~STATUS_MASK;
    localparam logic [FLAG_W-1:0] FLAG_RST    = FLAG_W'(1 << B_EP2_ROOM);
    localparam logic [FLAG_W-1:0] EN_RST      = '0;

    typedef enum logic {
        SEL_FLAGS  = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [FLAG_W-1:0] data;
    } cpu_wr_t;

    typedef struct packed {
        logic bus_reset;
        logic ep2_in_nodata;
        logic setup_done;
        logic ep0_out_done;
        logic ep0_in_req;
        logic ep0_in_done;
    } usb_events_t;

    typedef struct packed {
        logic ep1_full;
        logic ep2_room;
    } usb_status_t;

    // Place events and status levels at their register bit positions.
    function automatic logic [FLAG_W-1:0] place_hw(input usb_events_t ev, input usb_status_t st);
        logic [FLAG_W-1:0] v;
        v                = '0;
        v[B_BUS_RST]     = ev.bus_reset;
        v[B_EP1_FULL]    = st.ep1_full;
        v[B_EP2_REQ]     = ev.ep2_in_nodata;
        v[B_EP2_ROOM]    = st.ep2_room;
        v[B_SETUP]       = ev.setup_done;
        v[B_EP0_OUT]     = ev.ep0_out_done;
        v[B_EP0_IN_REQ]  = ev.ep0_in_req;
        v[B_EP0_IN_DONE] = ev.ep0_in_done;
        return v;
    endfunction

endpackage

// File: rtl/usb_irq_event_bit.sv
module usb_irq_event_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= RST_VAL;
        else if (set_i)
            q_o <= 1'b1;          // a new event beats a same-cycle clear
        else if (clr_i)
            q_o <= 1'b0;
    end
endmodule

// File: rtl/usb_irq_status_bit.sv
module usb_irq_status_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= RST_VAL;
        else
            q_o <= level_i;
    end
endmodule

// File: rtl/usb_irq_enable_reg.sv
module usb_irq_enable_reg #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= RST_VAL;
        else if (wr_i)
            q_o <= wdata_i;
    end
endmodule

// File: rtl/usb_irq_req.sv
module usb_irq_req #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] flags_i,
    input  logic [W-1:0] en_i,
    output logic         irq_o
);
    logic hit;
    assign hit = |(flags_i & en_i);

    always_ff @(posedge clk) begin
        if (rst)
            irq_o <= 1'b0;
        else
            irq_o <= hit;
    end
endmodule

// File: rtl/usb_irq_flags.sv
module usb_irq_flags
    import usb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [FLAG_W-1:0] reg_wdata,
    output logic [FLAG_W-1:0] reg_rdata,
    input  logic              ev_bus_reset,
    input  logic              ev_ep2_in_nodata,
    input  logic              ev_setup_done,
    input  logic              ev_ep0_out_done,
    input  logic              ev_ep0_in_req,
    input  logic              ev_ep0_in_done,
    input  logic              st_ep1_full,
    input  logic              st_ep2_room,
    output logic              irq
);
    cpu_wr_t           cpu;
    usb_events_t       ev;
    usb_status_t       st;
    logic [FLAG_W-1:0] hw_vec;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] en_q;
    logic              flag_wr;
    logic              en_wr;

    assign cpu.wr   = reg_wr;
    assign cpu.sel  = reg_sel_e'(reg_sel);
    assign cpu.data = reg_wdata;

    assign ev.bus_reset     = ev_bus_reset;
    assign ev.ep2_in_nodata = ev_ep2_in_nodata;
    assign ev.setup_done    = ev_setup_done;
    assign ev.ep0_out_done  = ev_ep0_out_done;
    assign ev.ep0_in_req    = ev_ep0_in_req;
    assign ev.ep0_in_done   = ev_ep0_in_done;
    assign st.ep1_full      = st_ep1_full;
    assign st.ep2_room      = st_ep2_room;

    assign hw_vec  = place_hw(ev, st);
    assign flag_wr = cpu.wr && (cpu.sel == SEL_FLAGS);
    assign en_wr   = cpu.wr && (cpu.sel == SEL_ENABLE);

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        if (STATUS_MASK[i]) begin : g_status
            usb_irq_status_bit #(.RST_VAL(FLAG_RST[i])) u_bit (
                .clk     (clk),
                .rst     (rst),
                .level_i (hw_vec[i]),
                .q_o     (flags_q[i])
            );
        end else begin : g_event
            usb_irq_event_bit #(.RST_VAL(FLAG_RST[i])) u_bit (
                .clk   (clk),
                .rst   (rst),
                .set_i (hw_vec[i]),
                .clr_i (flag_wr && !cpu.data[i]),
                .q_o   (flags_q[i])
            );
        end
    end

    usb_irq_enable_reg #(.W(FLAG_W), .RST_VAL(EN_RST)) u_en (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (en_wr),
        .wdata_i (cpu.data),
        .q_o     (en_q)
    );

    usb_irq_req #(.W(FLAG_W)) u_req (
        .clk     (clk),
        .rst     (rst),
        .flags_i (flags_q),
        .en_i    (en_q),
        .irq_o   (irq)
    );

    always_comb begin
        unique case (cpu.sel)
            SEL_FLAGS:  reg_rdata = flags_q;
            SEL_ENABLE: reg_rdata = en_q;
            default:    reg_rdata = flags_q;
        endcase
    end
endmodule

// File: rtl/usb_irq_flags_chk.sv
module usb_irq_flags_chk
    import usb_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [FLAG_W-1:0] reg_wdata,
    input logic [FLAG_W-1:0] hw_vec,
    input logic [FLAG_W-1:0] flags_q,
    input logic [FLAG_W-1:0] en_q,
    input logic              st_ep1_full,
    input logic              st_ep2_room,
    input logic              irq
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (flags_q == FLAG_RST) && (en_q == EN_RST) && !irq);

    // R2
    event_sets_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & $past(hw_vec) & LATCH_MASK) == ($past(hw_vec) & LATCH_MASK)));

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(hw_vec) & LATCH_MASK) == '0));

    // R3
    write_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_sel) |=>
            ((flags_q & LATCH_MASK & ~$past(reg_wdata) & ~$past(hw_vec)) == '0));

    // R4
    status_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (flags_q[B_EP1_FULL] == $past(st_ep1_full)) &&
                 (flags_q[B_EP2_ROOM] == $past(st_ep2_room)));

    // R6
    enable_load_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel) |=> (en_q == $past(reg_wdata)));

    // R7
    irq_timing_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|(flags_q & en_q))));
endmodule

bind usb_irq_flags usb_irq_flags_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .hw_vec      (hw_vec),
    .flags_q     (flags_q),
    .en_q        (en_q),
    .st_ep1_full (st_ep1_full),
    .st_ep2_room (st_ep2_room),
    .irq         (irq)
);

// File: tb/tb_usb_irq_flags.sv
module tb_usb_irq_flags;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] LATCH = 8'hAF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ev_bus_reset = 0, ev_ep2_in_nodata = 0, ev_setup_done = 0;
    logic       ev_ep0_out_done = 0, ev_ep0_in_req = 0, ev_ep0_in_done = 0;
    logic       st_ep1_full = 0, st_ep2_room = 0;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;
    logic [7:0] m_flags = 8'h10;
    logic [7:0] m_en    = 8'h00;
    logic       m_irq   = 1'b0;

    usb_irq_flags dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_bus_reset(ev_bus_reset), .ev_ep2_in_nodata(ev_ep2_in_nodata),
        .ev_setup_done(ev_setup_done), .ev_ep0_out_done(ev_ep0_out_done),
        .ev_ep0_in_req(ev_ep0_in_req), .ev_ep0_in_done(ev_ep0_in_done),
        .st_ep1_full(st_ep1_full), .st_ep2_room(st_ep2_room), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] next_flags(input logic [7:0] cur, input logic wr,
            input logic sel, input logic [7:0] wd, input logic [7:0] ev,
            input logic ep1, input logic room);
        logic [7:0] clr, n;
        clr = (wr && !sel) ? ~wd : 8'h00;
        n = ((cur & ~clr) | ev) & LATCH;
        n[6] = ep1;
        n[4] = room;
        return n;
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // One clock: drive, advance model, then compare both outputs.
    task automatic cyc(input logic wr, input logic sel, input logic [7:0] wd,
            input logic [7:0] ev, input logic ep1, input logic room,
            input string tf, input string te, input string ti);
        logic [7:0] ef;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        ev_bus_reset = ev[7]; ev_ep2_in_nodata = ev[5]; ev_setup_done = ev[3];
        ev_ep0_out_done = ev[2]; ev_ep0_in_req = ev[1]; ev_ep0_in_done = ev[0];
        st_ep1_full = ep1; st_ep2_room = room;
        ef = ev & LATCH;
        m_irq   = |(m_flags & m_en);
        m_flags = next_flags(m_flags, wr, sel, wd, ef, ep1, room);
        if (wr && sel) m_en = wd;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; ev_bus_reset = 0; ev_ep2_in_nodata = 0; ev_setup_done = 0;
        ev_ep0_out_done = 0; ev_ep0_in_req = 0; ev_ep0_in_done = 0;
        reg_sel = 1'b0;
        #1 check(tf, "flags", reg_rdata, m_flags);
        reg_sel = 1'b1;
        #1 check(te, "enable", reg_rdata, m_en);
        check(ti, "irq", {7'd0, irq}, {7'd0, m_irq});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] ev;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);

        // R1: state held in reset
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 reg_sel = 1'b0;
        #1 check("R1", "flags", reg_rdata, 8'h10);
        reg_sel = 1'b1;
        #1 check("R1", "enable", reg_rdata, 8'h00);
        check("R1", "irq", {7'd0, irq}, 8'h00);
        rst = 1'b0;

        // R2: each latched event on its own, then clear everything
        for (int b = 0; b < 8; b++) begin
            if (LATCH[b]) begin
                cyc(0, 0, 8'h00, 8'(1 << b), 0, 1, "R2", "R6", "R7");
                cyc(0, 0, 8'h00, 8'h00, 0, 1, "R2", "R6", "R7");
                cyc(1, 0, 8'h00, 8'h00, 0, 1, "R3", "R6", "R7");
            end
        end

        // R3: write of all ones changes nothing, single-bit clear keeps others
        cyc(0, 0, 8'h00, LATCH, 0, 1, "R2", "R6", "R7");
        cyc(1, 0, 8'hFF, 8'h00, 0, 1, "R3", "R6", "R7");
        cyc(1, 0, 8'hF7, 8'h00, 0, 1, "R3", "R6", "R7");

        // R4: status bits follow inputs and ignore clearing writes
        cyc(1, 0, 8'h00, 8'h00, 1, 0, "R4", "R6", "R7");
        cyc(1, 0, 8'h00, 8'h00, 1, 0, "R4", "R6", "R7");
        cyc(1, 0, 8'hFF, 8'h00, 0, 1, "R4", "R6", "R7");

        // R5: set beats clear in the same cycle
        cyc(1, 0, 8'h00, 8'h80, 0, 1, "R5", "R6", "R7");
        cyc(1, 0, 8'h7F, 8'h00, 0, 1, "R3", "R6", "R7");

        // R6: enable register loads and reads back
        cyc(1, 1, 8'hA5, 8'h00, 0, 1, "R6", "R6", "R7");
        cyc(1, 1, 8'h00, 8'h00, 0, 1, "R6", "R6", "R7");

        // R7: irq lags the flag by one edge
        cyc(1, 1, 8'h01, 8'h00, 0, 0, "R7", "R6", "R7");
        cyc(0, 0, 8'h00, 8'h01, 0, 0, "R7", "R6", "R7");
        cyc(0, 0, 8'h00, 8'h00, 0, 0, "R7", "R6", "R7");
        cyc(1, 0, 8'hFE, 8'h00, 0, 0, "R7", "R6", "R7");
        cyc(0, 0, 8'h00, 8'h00, 0, 0, "R7", "R6", "R7");

        // Random mix
        for (int k = 0; k < 4000; k++) begin
            logic wr, sel;
            ev  = 8'($urandom) & 8'($urandom) & 8'($urandom);
            wr  = ($urandom % 4) == 0;
            sel = ($urandom % 3) == 0;
            cyc(wr, sel, 8'($urandom) | 8'($urandom), ev,
                1'($urandom), 1'($urandom), "R3", "R6", "R7");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule